// File: doc/BRIEF.md
# BCD Calendar Register Bank

This block keeps time of day and a calendar as a set of independent 4-bit BCD digit registers. The digits are tenths of seconds, seconds, minutes, hours, day of month, month and day of week. A host reaches them through a nibble-wide, strobe-based bus that has a chip select and a 4-bit register address. A single-cycle 10 Hz tick pulse advances the chain. All carries resolve in the cycle of the tick, so every digit holds a consistent value on the following cycle.

Leap years are tracked by a write-only one-hot status register. It rotates once a year, so February gets its 29th day every fourth year. A run/stop control freezes the chain and holds the sub-minute digits at zero while software loads a time. A data-changed flag turns any read that overlaps an update into the all-ones code 1111, which is not valid BCD. Software therefore reads again whenever it sees that code.

Top module: `rtc_nibble_bank`

## Requirements
- R1: After reset the clock is stopped. Tenths, seconds, minutes and hours read 0. The day-of-month units digit, the month units digit and the day of week read 1. Ticks while stopped change no digit.
- R2: While running, each tick advances tenths (address 1). Tenths goes 9→0 with a carry into seconds (units at address 2, tens at address 3). Seconds go 59→00 with a carry into minutes (units at address 4, tens at address 5).
- R3: Hours (units at address 6, tens at address 7) count in 24-hour form. A carry out of 23:59 gives 00:00 and advances both the day of month and the day of week in the same tick.
- R4: Day of week (address 10, 3 bits) counts 1 to 7 and then returns to 1.
- R5: Day of month (units at address 8, tens at address 9) goes back to 01 after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12. At that point the month (units at address 11, tens at address 12) advances, and month 12 returns to 01.
- R6: In month 2, day of month goes back to 01 after day 29 when bit 3 (written through data bit 3) of the year status register is set, and after day 28 otherwise.
- R7: The year status register (write-only, address 13) rotates one place toward bit 0 on the tick that carries December 31 23:59:59.9 into January 1. Bit 0 moves to bit 3. So 1000 (leap) goes to 0100, then 0010, then 0001, then back to 1000.
- R8: Writing data bit 0 = 0 to address 14 stops the clock and holds tenths and both seconds digits at 0. Writing 1 starts it again, and the first tick after the start gives tenths = 1.
- R9: Data bits that a register does not use are dropped on writes and read as 0. The widths are: seconds tens 3, minutes tens 3, hours tens 2, days tens 2, day of week 3, months tens 1. Addresses 1 to 3 ignore writes. Addresses 0, 13, 14 and 15 read as 0.
- R10: Each tick that is applied sets a data-changed flag, and any read clears it. A read returns 1111 when the flag is set or when a tick is applied in the same cycle. The read data stays unchanged between reads.
- R11: Writes to addresses 4 to 12 load the digit as written, masked to its width, with no range check. For example, 1111 written to hours units reads back as 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Single-cycle 10 Hz advance pulse |
| cs_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe, sampled with cs_i on the clock edge |
| wr_i | input | 1 | Write strobe, sampled with cs_i on the clock edge |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data nibble |
| rdata_o | output | 4 | Read data, registered, updated on each read |

## Verification
The sub-minute chain is driven from 00:00 in steps of seven ticks. Each step is compared with tenths, seconds and minutes derived from the running tick total, which separates the tenths, seconds-units and seconds-tens carry points from one another.

The calendar is tested from day 28 to day 31 of every month, each time from 23:59 with a rotating day of week. This covers the month-length table, the day-of-week wrap and the year rollover separately from the time digits.

The leap rotation starts from 0100 and checks February once after each rollover. Only the third rollover may give a 29th day, so the direction of the shift shows in the result.

Further cases cover reads that follow or coincide with a tick, ticks while stopped, masked writes and writes to read-only addresses.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NIB_W  = 4;
  localparam int ADDR_W = 4;
  localparam int NREG   = 1 << ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    A_TEST   = 4'd0,
    A_TENTHS = 4'd1,
    A_SEC_U  = 4'd2,
    A_SEC_T  = 4'd3,
    A_MIN_U  = 4'd4,
    A_MIN_T  = 4'd5,
    A_HR_U   = 4'd6,
    A_HR_T   = 4'd7,
    A_DAY_U  = 4'd8,
    A_DAY_T  = 4'd9,
    A_WDAY   = 4'd10,
    A_MON_U  = 4'd11,
    A_MON_T  = 4'd12,
    A_YEAR   = 4'd13,
    A_RUN    = 4'd14,
    A_IRQ    = 4'd15
  } reg_addr_e;

  // Last day of the month as BCD {tens[1:0], units[3:0]}.
  function automatic logic [5:0] month_last_day(input logic       mon_t,
                                                input logic [3:0] mon_u,
                                                input logic       leap);
    logic [5:0] r;
    r = {2'd3, 4'd1};
    if (mon_t) begin
      if (mon_u == 4'd1) r = {2'd3, 4'd0};
    end else begin
      case (mon_u)
        4'd2:                r = leap ? {2'd2, 4'd9} : {2'd2, 4'd8};
        4'd4, 4'd6, 4'd9:    r = {2'd3, 4'd0};
        default:             r = {2'd3, 4'd1};
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_bcd_pair.sv
module rtc_bcd_pair #(
  parameter int TENS_W  = 3,
  parameter int RESTART = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              clr_i,
  input  logic [TENS_W-1:0] lim_tens_i,
  input  logic [3:0]        lim_units_i,
  input  logic              wr_units_i,
  input  logic              wr_tens_i,
  input  logic [3:0]        wdata_i,
  output logic [3:0]        units_o,
  output logic [TENS_W-1:0] tens_o,
  output logic              carry_o
);

  logic [3:0]        units_q, units_d;
  logic [TENS_W-1:0] tens_q, tens_d;
  logic              at_lim, upd_en;

  assign at_lim  = (tens_q == lim_tens_i) && (units_q == lim_units_i);
  assign carry_o = inc_i && at_lim;
  assign upd_en  = inc_i || clr_i || wr_units_i || wr_tens_i;

  always_comb begin
    units_d = units_q;
    tens_d  = tens_q;
    if (clr_i) begin
      units_d = 4'(RESTART);
      tens_d  = '0;
    end else begin
      if (inc_i) begin
        if (at_lim) begin
          units_d = 4'(RESTART);
          tens_d  = '0;
        end else if (units_q >= 4'd9) begin
          units_d = 4'd0;
          tens_d  = tens_q + TENS_W'(1);
        end else begin
          units_d = units_q + 4'd1;
        end
      end
      if (wr_units_i) units_d = wdata_i;
      if (wr_tens_i)  tens_d  = wdata_i[TENS_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      units_q <= 4'(RESTART);
      tens_q  <= '0;
    end else if (upd_en) begin
      units_q <= units_d;
      tens_q  <= tens_d;
    end
  end

  assign units_o = units_q;
  assign tens_o  = tens_q;

endmodule

// File: rtl/rtc_week_leap.sv
module rtc_week_leap #(
  parameter int WDAY_W  = 3,
  parameter int WDAY_N  = 7,
  parameter int YEAR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              day_inc_i,
  input  logic              year_inc_i,
  input  logic              wr_wday_i,
  input  logic              wr_year_i,
  input  logic [3:0]        wdata_i,
  output logic [WDAY_W-1:0] wday_o,
  output logic [YEAR_W-1:0] year_o
);

  logic [WDAY_W-1:0] wday_q, wday_d;
  logic [YEAR_W-1:0] year_q, year_d;
  logic              wday_en, year_en;

  assign wday_en = day_inc_i || wr_wday_i;
  assign year_en = year_inc_i || wr_year_i;

  always_comb begin
    wday_d = wday_q;
    if (wr_wday_i)                           wday_d = wdata_i[WDAY_W-1:0];
    else if (wday_q == WDAY_W'(WDAY_N))      wday_d = WDAY_W'(1);
    else                                     wday_d = wday_q + WDAY_W'(1);
  end

  always_comb begin
    year_d = year_q;
    if (wr_year_i) year_d = wdata_i[YEAR_W-1:0];
    else           year_d = {year_q[0], year_q[YEAR_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wday_q <= WDAY_W'(1);
    else if (wday_en) wday_q <= wday_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      year_q <= {1'b1, {(YEAR_W-1){1'b0}}};
    else if (year_en) year_q <= year_d;
  end

  assign wday_o = wday_q;
  assign year_o = year_q;

endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port
  import rtc_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       upd_i,
  input  logic [NREG-1:0][NIB_W-1:0] rd_vals_i,
  output logic [NREG-1:0]            wr_sel_o,
  output logic [NIB_W-1:0]           rdata_o
);

  logic             rd_go, wr_go;
  logic             dirty_q, dirty_d;
  logic [NIB_W-1:0] rdata_q, rdata_d;

  assign rd_go = cs_i && rd_i;
  assign wr_go = cs_i && wr_i;

  for (genvar i = 0; i < NREG; i++) begin : g_wdec
    assign wr_sel_o[i] = wr_go && (addr_i == ADDR_W'(i));
  end

  always_comb begin
    dirty_d = dirty_q;
    if (rd_go)      dirty_d = 1'b0;
    else if (upd_i) dirty_d = 1'b1;
  end

  always_comb begin
    if (dirty_q || upd_i) rdata_d = '1;
    else                  rdata_d = rd_vals_i[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dirty_q <= 1'b0;
    else         dirty_q <= dirty_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_go) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/rtc_nibble_bank.sv
module rtc_nibble_bank
  import rtc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [NIB_W-1:0]  rdata_o
);

  // reset release synchronizer
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  logic [NREG-1:0]            wr_sel;
  logic [NREG-1:0][NIB_W-1:0] rd_vals;

  // run control
  logic run_q, run_d, run_en, tick_go;
  assign run_en  = wr_sel[A_RUN];
  assign run_d   = wdata_i[0];
  assign tick_go = tick_i && run_q;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  run_q <= 1'b0;
    else if (run_en)  run_q <= run_d;
  end

  // tenths digit
  logic [3:0] tenths_q, tenths_d;
  logic       tenths_en, tenths_carry;

  assign tenths_en    = !run_q || tick_go;
  assign tenths_carry = tick_go && (tenths_q >= 4'd9);

  always_comb begin
    tenths_d = tenths_q;
    if (!run_q)            tenths_d = 4'd0;
    else if (tenths_carry) tenths_d = 4'd0;
    else if (tick_go)      tenths_d = tenths_q + 4'd1;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)    tenths_q <= 4'd0;
    else if (tenths_en) tenths_q <= tenths_d;
  end

  // digit pairs
  logic [3:0] sec_u, min_u, hr_u, day_u, mon_u;
  logic [2:0] sec_t, min_t;
  logic [1:0] hr_t, day_t;
  logic       mon_t;
  logic       sec_carry, min_carry, day_carry, mon_carry, year_carry;
  logic [1:0] dlim_t;
  logic [3:0] dlim_u;
  logic [2:0] wday_q;
  logic [3:0] leap_q;

  assign {dlim_t, dlim_u} = month_last_day(mon_t, mon_u, leap_q[3]);

  rtc_bcd_pair #(.TENS_W(3), .RESTART(0)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .inc_i(tenths_carry), .clr_i(!run_q),
    .lim_tens_i(3'd5), .lim_units_i(4'd9),
    .wr_units_i(1'b0), .wr_tens_i(1'b0), .wdata_i(wdata_i),
    .units_o(sec_u), .tens_o(sec_t), .carry_o(sec_carry)
  );

  rtc_bcd_pair #(.TENS_W(3), .RESTART(0)) u_min (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .inc_i(sec_carry), .clr_i(1'b0),
    .lim_tens_i(3'd5), .lim_units_i(4'd9),
    .wr_units_i(wr_sel[A_MIN_U]), .wr_tens_i(wr_sel[A_MIN_T]), .wdata_i(wdata_i),
    .units_o(min_u), .tens_o(min_t), .carry_o(min_carry)
  );

  rtc_bcd_pair #(.TENS_W(2), .RESTART(0)) u_hour (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .inc_i(min_carry), .clr_i(1'b0),
    .lim_tens_i(2'd2), .lim_units_i(4'd3),
    .wr_units_i(wr_sel[A_HR_U]), .wr_tens_i(wr_sel[A_HR_T]), .wdata_i(wdata_i),
    .units_o(hr_u), .tens_o(hr_t), .carry_o(day_carry)
  );

  rtc_bcd_pair #(.TENS_W(2), .RESTART(1)) u_mday (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .inc_i(day_carry), .clr_i(1'b0),
    .lim_tens_i(dlim_t), .lim_units_i(dlim_u),
    .wr_units_i(wr_sel[A_DAY_U]), .wr_tens_i(wr_sel[A_DAY_T]), .wdata_i(wdata_i),
    .units_o(day_u), .tens_o(day_t), .carry_o(mon_carry)
  );

  rtc_bcd_pair #(.TENS_W(1), .RESTART(1)) u_month (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .inc_i(mon_carry), .clr_i(1'b0),
    .lim_tens_i(1'b1), .lim_units_i(4'd2),
    .wr_units_i(wr_sel[A_MON_U]), .wr_tens_i(wr_sel[A_MON_T]), .wdata_i(wdata_i),
    .units_o(mon_u), .tens_o(mon_t), .carry_o(year_carry)
  );

  rtc_week_leap #(.WDAY_W(3), .WDAY_N(7), .YEAR_W(4)) u_week_leap (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .day_inc_i(day_carry), .year_inc_i(year_carry),
    .wr_wday_i(wr_sel[A_WDAY]), .wr_year_i(wr_sel[A_YEAR]),
    .wdata_i(wdata_i), .wday_o(wday_q), .year_o(leap_q)
  );

  // read values; unused bits and write-only addresses read 0
  always_comb begin
    rd_vals           = '0;
    rd_vals[A_TENTHS] = tenths_q;
    rd_vals[A_SEC_U]  = sec_u;
    rd_vals[A_SEC_T]  = {1'b0, sec_t};
    rd_vals[A_MIN_U]  = min_u;
    rd_vals[A_MIN_T]  = {1'b0, min_t};
    rd_vals[A_HR_U]   = hr_u;
    rd_vals[A_HR_T]   = {2'b00, hr_t};
    rd_vals[A_DAY_U]  = day_u;
    rd_vals[A_DAY_T]  = {2'b00, day_t};
    rd_vals[A_WDAY]   = {1'b0, wday_q};
    rd_vals[A_MON_U]  = mon_u;
    rd_vals[A_MON_T]  = {3'b000, mon_t};
  end

  rtc_bus_port u_port (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .upd_i(tick_go), .rd_vals_i(rd_vals),
    .wr_sel_o(wr_sel), .rdata_o(rdata_o)
  );

endmodule

// File: rtl/rtc_nibble_bank_chk.sv
module rtc_nibble_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic        tick_i,
  input logic        run_q,
  input logic [3:0]  rdata_o,
  input logic [3:0]  tenths_q,
  input logic [3:0]  sec_u,
  input logic [2:0]  sec_t,
  input logic [3:0]  min_u,
  input logic [2:0]  min_t,
  input logic [2:0]  wday_q,
  input logic [3:0]  leap_q,
  input logic        day_carry,
  input logic        year_carry,
  input logic [15:0] wr_sel
);

  a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (tenths_q == 4'd0 && sec_u == 4'd0 && sec_t == 3'd0));

  a_r2_tenths_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    tenths_q <= 4'd9);

  a_r1_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_i) |=> ($stable(min_u) && $stable(min_t)));

  a_r10_overlap_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && rd_i && tick_i && run_q) |=> rdata_o == 4'hF);

  a_r10_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_i && rd_i) |=> $stable(rdata_o));

  a_r4_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && wday_q == 3'd7 && !wr_sel[10]) |=> wday_q == 3'd1);

  a_r7_leap_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (year_carry && !wr_sel[13]) |=> leap_q == {$past(leap_q[0]), $past(leap_q[3:1])});

endmodule

bind rtc_nibble_bank rtc_nibble_bank_chk u_chk (
  .clk(clk_i), .rst_n(rst_sync_n), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
  .tick_i(tick_i), .run_q(run_q), .rdata_o(rdata_o), .tenths_q(tenths_q),
  .sec_u(sec_u), .sec_t(sec_t), .min_u(min_u), .min_t(min_t),
  .wday_q(wday_q), .leap_q(leap_q), .day_carry(day_carry),
  .year_carry(year_carry), .wr_sel(wr_sel)
);

// File: tb/rtc_nibble_bank_bench.sv
module rtc_nibble_bank_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cs = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [3:0] wdata = 4'd0;
  logic [3:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rtc_nibble_bank u_rtc_nibble_bank (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cs_i(cs), .rd_i(rd),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = 4'(a); wdata = 4'(d);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [3:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = 4'(a);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    v = rdata;
  endtask

  // first read absorbs a pending data-changed flag
  task automatic rd_clean(input int a, output logic [3:0] v);
    logic [3:0] dummy;
    rd_reg(a, dummy);
    rd_reg(a, v);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_date(input int m, input int d, input int hh, input int mm, input int w);
    wr_reg(14, 0);
    wr_reg(11, m % 10); wr_reg(12, m / 10);
    wr_reg(8, d % 10);  wr_reg(9, d / 10);
    wr_reg(6, hh % 10); wr_reg(7, hh / 10);
    wr_reg(4, mm % 10); wr_reg(5, mm / 10);
    wr_reg(10, w);
  endtask

  function automatic int days_in(input int m, input bit leap);
    case (m)
      2:             return leap ? 29 : 28;
      4, 6, 9, 11:   return 30;
      default:       return 31;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] v;
    int t_total;
    int wcnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_clean(1, v);  chk("R1 tenths", v, 4'd0);
    rd_clean(4, v);  chk("R1 min units", v, 4'd0);
    rd_clean(6, v);  chk("R1 hour units", v, 4'd0);
    rd_clean(8, v);  chk("R1 day units", v, 4'd1);
    rd_clean(11, v); chk("R1 month units", v, 4'd1);
    rd_clean(10, v); chk("R1 weekday", v, 4'd1);
    ticks(5);
    rd_reg(1, v);    chk("R1 ticks ignored while stopped (no flag)", v, 4'd0);
    rd_reg(2, v);    chk("R1 seconds unchanged", v, 4'd0);

    // R9 masking and read-only / write-only addresses
    wr_reg(10, 15); rd_clean(10, v); chk("R9 weekday mask", v, 4'd7);
    wr_reg(7, 15);  rd_clean(7, v);  chk("R9 hour tens mask", v, 4'd3);
    wr_reg(12, 15); rd_clean(12, v); chk("R9 month tens mask", v, 4'd1);
    wr_reg(5, 15);  rd_clean(5, v);  chk("R9 min tens mask", v, 4'd7);
    wr_reg(9, 15);  rd_clean(9, v);  chk("R9 day tens mask", v, 4'd3);
    wr_reg(1, 7);   rd_clean(1, v);  chk("R9 tenths read-only", v, 4'd0);
    wr_reg(2, 7);   rd_clean(2, v);  chk("R9 sec units read-only", v, 4'd0);
    wr_reg(3, 5);   rd_clean(3, v);  chk("R9 sec tens read-only", v, 4'd0);
    for (int a = 13; a <= 15; a++) begin
      rd_clean(a, v); chk("R9 write-only reads zero", v, 4'd0);
    end
    rd_clean(0, v); chk("R9 test address reads zero", v, 4'd0);
    wr_reg(14, 0);

    // R11 direct load without range check
    wr_reg(6, 15);  rd_clean(6, v);  chk("R11 hour units raw", v, 4'hF);
    wr_reg(8, 12);  rd_clean(8, v);  chk("R11 day units raw", v, 4'hC);
    wr_reg(4, 11);  rd_clean(4, v);  chk("R11 min units raw", v, 4'hB);

    // R8 start and first tick; R10 flag behaviour
    set_date(1, 1, 0, 0, 1);
    wr_reg(14, 1);
    ticks(1);
    rd_reg(1, v);  chk("R10 read after tick gives ones", v, 4'hF);
    rd_reg(1, v);  chk("R8 first tick gives tenths 1", v, 4'd1);
    rd_reg(1, v);  chk("R10 flag cleared by read", v, 4'd1);
    @(negedge clk);
    tick = 1'b1; cs = 1'b1; rd = 1'b1; addr = 4'd1;
    @(negedge clk);
    tick = 1'b0; cs = 1'b0; rd = 1'b0;
    chk("R10 read overlapping tick gives ones", rdata, 4'hF);
    rd_reg(1, v);  chk("R10 next read valid", v, 4'd2);
    repeat (3) @(negedge clk);
    chk("R10 read data held between reads", rdata, 4'd2);

    // R8 stop holds sub-minute digits at zero
    ticks(25);
    wr_reg(14, 0);
    rd_clean(1, v); chk("R8 stop clears tenths", v, 4'd0);
    rd_clean(2, v); chk("R8 stop clears sec units", v, 4'd0);
    ticks(4);
    rd_reg(2, v);   chk("R8 ticks ignored while stopped", v, 4'd0);

    // R2 sub-minute sweep
    set_date(1, 1, 0, 0, 1);
    wr_reg(14, 1);
    t_total = 0;
    for (int s = 0; s < 181; s++) begin
      ticks(7);
      t_total += 7;
      rd_clean(1, v); chk("R2 tenths", v, 4'(t_total % 10));
      rd_clean(2, v); chk("R2 sec units", v, 4'((t_total / 10) % 10));
      rd_clean(3, v); chk("R2 sec tens", v, 4'((t_total / 100) % 6));
      rd_clean(4, v); chk("R2 min units", v, 4'((t_total / 600) % 10));
    end

    // R3 R4 R5 R6 calendar sweep with leap bit clear (0001)
    wr_reg(13, 1);
    wcnt = 0;
    for (int m = 1; m <= 12; m++) begin
      for (int d = 28; d <= 31; d++) begin
        int lim, ed, em, w;
        lim = days_in(m, 1'b0);
        if (d > lim) continue;
        w = (wcnt % 7) + 1;
        wcnt++;
        set_date(m, d, 23, 59, w);
        wr_reg(14, 1);
        ticks(600);
        wr_reg(14, 0);
        ed = (d < lim) ? d + 1 : 1;
        em = (d < lim) ? m : ((m == 12) ? 1 : m + 1);
        rd_clean(8, v);  chk("R5 day units", v, 4'(ed % 10));
        rd_clean(9, v);  chk("R5 day tens", v, 4'(ed / 10));
        rd_clean(11, v); chk("R5 month units", v, 4'(em % 10));
        rd_clean(12, v); chk("R5 month tens", v, 4'(em / 10));
        rd_clean(10, v); chk("R4 weekday advance", v, 4'((w % 7) + 1));
        rd_clean(6, v);  chk("R3 hour units wrap", v, 4'd0);
        rd_clean(7, v);  chk("R3 hour tens wrap", v, 4'd0);
        rd_clean(4, v);  chk("R3 min units wrap", v, 4'd0);
      end
    end

    // R6 February in a leap year
    wr_reg(13, 8);
    set_date(2, 28, 23, 59, 3);
    wr_reg(14, 1); ticks(600); wr_reg(14, 0);
    rd_clean(8, v);  chk("R6 leap feb 29 units", v, 4'd9);
    rd_clean(9, v);  chk("R6 leap feb 29 tens", v, 4'd2);
    set_date(2, 29, 23, 59, 3);
    wr_reg(14, 1); ticks(600); wr_reg(14, 0);
    rd_clean(8, v);  chk("R6 leap feb rolls after 29", v, 4'd1);
    rd_clean(11, v); chk("R6 leap feb to march", v, 4'd3);

    // R7 rotation direction: from 0100 only the third rollover is leap
    wr_reg(13, 4);
    for (int r = 1; r <= 4; r++) begin
      set_date(12, 31, 23, 59, 1);
      wr_reg(14, 1); ticks(600); wr_reg(14, 0);
      rd_clean(11, v); chk("R7 year rollover month", v, 4'd1);
      set_date(2, 28, 23, 59, 1);
      wr_reg(14, 1); ticks(600); wr_reg(14, 0);
      rd_clean(8, v);
      chk("R7 february after rollover", v, (r == 3) ? 4'd9 : 4'd1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule